// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This block gives a processor core four address breakpoints, a sticky status word and a control word. All of them sit in a small indexed register file that a debug agent reads and writes. In every cycle the unit compares the CPU event on its input against each enabled breakpoint. The event is either an instruction fetch or a data read or write, and it carries an address and a size. Each breakpoint has its own access-type and length fields, and these are packed into the upper half of the control word.

When one or more breakpoints match, the unit latches a status bit for each of them. It raises a one-cycle trap pulse on the following cycle. A single-step event and a task-switch event also set their own status flags and also raise the pulse. A task switch also clears every per-breakpoint local enable and leaves the global enables as they were. Exception delivery and privilege handling belong to the surrounding core.

Top module: `bkpt_match_unit`

## Requirements
- R1: After synchronous reset, all four address registers and the control word read 0, the status word reads 0xFFFF0FF0, and trap_pulse is 0.
- R2: Register index 0 to 3 selects breakpoint address 0 to 3, index 6 selects status and index 7 selects control. Indices 4 and 5 read as 0, and a write to them changes no register.
- R3: Status bits under mask 0xFFFF0FF0 always read 1. Bits 0-3 and 12-15 store the value written, so a written 0x0000A005 reads back as 0xFFFFAFF5.
- R4: Control bits under mask 0x0000FC00 always read 0. All other control bits, including bits 8 and 9, store the value written.
- R5: Breakpoint i is active when control bit 2i (local) or bit 2i+1 (global) is 1. When both are 0 it never matches.
- R6: The access code of breakpoint i is control bits [17+4i:16+4i]. Code 00 matches only fetch events whose address equals the breakpoint address exactly. Code 01 matches only data writes. Code 11 matches data reads and data writes. Code 10 never matches.
- R7: The length code of breakpoint i is control bits [19+4i:18+4i]. Codes 00, 01, 11 and 10 mean 1, 2, 4 and 8 bytes, and the low 0, 1, 2 or 3 breakpoint address bits are ignored. A data access of 2^evt_size bytes at evt_addr hits when any of its bytes lies inside the aligned breakpoint range.
- R8: Status bits 0-3 are sticky: a hit on breakpoint i sets bit i, and only a status write clears it. An event in the same cycle as a status write sets its bit on top of the written value.
- R9: A step_evt cycle sets status bit 14, and a tswitch_evt cycle sets status bit 15.
- R10: A tswitch_evt cycle clears control bits under mask 0x55 and keeps every other control bit.
- R11: trap_pulse is 1 for exactly the one cycle after a cycle with a breakpoint hit, step_evt or tswitch_evt, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_idx | input | 3 | Register index for read and write |
| reg_wr_en | input | 1 | Write strobe for the indexed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data of the indexed register |
| evt_valid | input | 1 | A CPU event is presented this cycle |
| evt_is_fetch | input | 1 | Event is an instruction fetch (else data access) |
| evt_is_write | input | 1 | Data access is a write (else read) |
| evt_addr | input | 32 | Event address |
| evt_size | input | 2 | Data access size as log2 of the byte count |
| step_evt | input | 1 | Single-step event |
| tswitch_evt | input | 1 | Task-switch event |
| trap_pulse | output | 1 | One-cycle debug trap indication |

## Verification
The main sweep places breakpoint 0 at an 8-byte-aligned address and then at an unaligned one. For each placement it tries every access code and every length code against fetches, reads and writes of all four sizes, at offsets from -8 to +8 bytes. This separates exact fetch matching from range overlap, separates write-only from read-write types, and shows the low-bit masking of each non-monotonic length code. A second sweep tries all 256 patterns of the enable byte against four breakpoints at the same address, which shows that the local and global enables work independently for each breakpoint. Directed sequences cover sticky accumulation, the merge of a status write with a hit in the same cycle, task-switch clearing followed by a miss on a local-only breakpoint, and the reserved-bit masks.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    localparam int unsigned REG_W    = 32;
    localparam int unsigned NUM_BP   = 4;
    localparam int unsigned IDX_W    = 3;
    localparam int unsigned CFG_BASE = 16;
    localparam int unsigned CFG_W    = 4;

    localparam logic [IDX_W-1:0] IDX_STATUS  = 3'd6;
    localparam logic [IDX_W-1:0] IDX_CONTROL = 3'd7;

    localparam logic [REG_W-1:0] STS_ONES   = 32'hFFFF_0FF0;
    localparam logic [REG_W-1:0] STS_KEEP   = ~STS_ONES;
    localparam logic [REG_W-1:0] CTL_ZERO   = 32'h0000_FC00;
    localparam logic [REG_W-1:0] CTL_KEEP   = ~CTL_ZERO;
    localparam logic [REG_W-1:0] CTL_LOCALS = 32'h0000_0055;

    localparam int unsigned STS_STEP_BIT = 14;
    localparam int unsigned STS_TSW_BIT  = 15;

    typedef enum logic [1:0] {
        ACC_EXEC  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_NONE  = 2'b10,
        ACC_RDWR  = 2'b11
    } access_kind_e;

    typedef struct packed {
        logic         local_en;
        logic         global_en;
        access_kind_e kind;
        logic [1:0]   len_code;
    } bp_cfg_t;

    // Number of ignored low address bits for a length code.
    function automatic logic [1:0] len_lsbs(input logic [1:0] code);
        logic [1:0] r;
        unique case (code)
            2'b00:   r = 2'd0;
            2'b01:   r = 2'd1;
            2'b11:   r = 2'd2;
            default: r = 2'd3;
        endcase
        return r;
    endfunction

    function automatic bp_cfg_t decode_cfg(input logic [REG_W-1:0] ctl,
                                           input int unsigned idx);
        bp_cfg_t r;
        r.local_en  = ctl[2*idx];
        r.global_en = ctl[2*idx+1];
        r.kind      = access_kind_e'(ctl[CFG_BASE + CFG_W*idx +: 2]);
        r.len_code  = ctl[CFG_BASE + CFG_W*idx + 2 +: 2];
        return r;
    endfunction

endpackage

// File: rtl/bkpt_comparator.sv
module bkpt_comparator
    import bkpt_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] bp_addr,
    input  bp_cfg_t           cfg,
    input  logic              evt_valid,
    input  logic              evt_is_fetch,
    input  logic              evt_is_write,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic [1:0]        evt_size,
    output logic              hit
);

    logic [ADDR_W-1:0] low_mask;
    logic [ADDR_W:0]   acc_span;
    logic [ADDR_W:0]   acc_lo, acc_hi, bp_lo, bp_hi;
    logic              overlap;
    logic              active;

    always_comb begin
        low_mask = ~({ADDR_W{1'b1}} << len_lsbs(cfg.len_code));
        acc_span = ~({(ADDR_W+1){1'b1}} << evt_size);
        acc_lo   = {1'b0, evt_addr};
        acc_hi   = acc_lo + acc_span;
        bp_lo    = {1'b0, bp_addr & ~low_mask};
        bp_hi    = bp_lo + {1'b0, low_mask};
        overlap  = (acc_lo <= bp_hi) && (bp_lo <= acc_hi);
        active   = cfg.local_en | cfg.global_en;
    end

    always_comb begin
        hit = 1'b0;
        if (evt_valid && active) begin
            unique case (cfg.kind)
                ACC_EXEC:  hit = evt_is_fetch && (evt_addr == bp_addr);
                ACC_WRITE: hit = !evt_is_fetch && evt_is_write && overlap;
                ACC_RDWR:  hit = !evt_is_fetch && overlap;
                default:   hit = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/bkpt_ctrl_reg.sv
module bkpt_ctrl_reg
    import bkpt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             tswitch,
    output logic [REG_W-1:0] ctrl_q
);

    logic [REG_W-1:0] ctrl_next;

    always_comb begin
        ctrl_next = wr_en ? (wdata & CTL_KEEP) : ctrl_q;
        if (tswitch) begin
            ctrl_next = ctrl_next & ~CTL_LOCALS;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_next;
        end
    end

endmodule

// File: rtl/bkpt_status_reg.sv
module bkpt_status_reg
    import bkpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wdata,
    input  logic [NUM_BP-1:0] hits,
    input  logic              step,
    input  logic              tswitch,
    output logic [REG_W-1:0]  status_rd,
    output logic              trap_pulse
);

    logic [REG_W-1:0] sts_q;
    logic [REG_W-1:0] sts_next;
    logic             any_event;

    always_comb begin
        sts_next = (wr_en ? wdata : sts_q) & STS_KEEP;
        sts_next[NUM_BP-1:0]  = sts_next[NUM_BP-1:0] | hits;
        sts_next[STS_STEP_BIT] = sts_next[STS_STEP_BIT] | step;
        sts_next[STS_TSW_BIT]  = sts_next[STS_TSW_BIT] | tswitch;
        any_event = (|hits) | step | tswitch;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q      <= '0;
            trap_pulse <= 1'b0;
        end else begin
            sts_q      <= sts_next;
            trap_pulse <= any_event;
        end
    end

    assign status_rd = sts_q | STS_ONES;

endmodule

// File: rtl/bkpt_match_unit.sv
module bkpt_match_unit
    import bkpt_pkg::*;
#(
    parameter int unsigned ADDR_W = REG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic              reg_wr_en,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              evt_valid,
    input  logic              evt_is_fetch,
    input  logic              evt_is_write,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic [1:0]        evt_size,
    input  logic              step_evt,
    input  logic              tswitch_evt,
    output logic              trap_pulse
);

    logic [ADDR_W-1:0] bp_addr_q [NUM_BP];
    logic [NUM_BP-1:0] hit_vec;
    logic [REG_W-1:0]  ctrl_word;
    logic [REG_W-1:0]  status_word;
    logic              wr_ctrl, wr_status;

    assign wr_ctrl   = reg_wr_en && (reg_idx == IDX_CONTROL);
    assign wr_status = reg_wr_en && (reg_idx == IDX_STATUS);

    for (genvar g = 0; g < NUM_BP; g++) begin : g_bp
        always_ff @(posedge clk) begin
            if (rst) begin
                bp_addr_q[g] <= '0;
            end else if (reg_wr_en && (reg_idx == IDX_W'(g))) begin
                bp_addr_q[g] <= reg_wdata[ADDR_W-1:0];
            end
        end

        bkpt_comparator #(.ADDR_W(ADDR_W)) u_cmp (
            .bp_addr      (bp_addr_q[g]),
            .cfg          (decode_cfg(ctrl_word, g)),
            .evt_valid    (evt_valid),
            .evt_is_fetch (evt_is_fetch),
            .evt_is_write (evt_is_write),
            .evt_addr     (evt_addr),
            .evt_size     (evt_size),
            .hit          (hit_vec[g])
        );
    end

    bkpt_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_ctrl),
        .wdata   (reg_wdata),
        .tswitch (tswitch_evt),
        .ctrl_q  (ctrl_word)
    );

    bkpt_status_reg u_status (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_status),
        .wdata      (reg_wdata),
        .hits       (hit_vec),
        .step       (step_evt),
        .tswitch    (tswitch_evt),
        .status_rd  (status_word),
        .trap_pulse (trap_pulse)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_idx < IDX_W'(NUM_BP)) begin
            reg_rdata = REG_W'(bp_addr_q[reg_idx[1:0]]);
        end else if (reg_idx == IDX_STATUS) begin
            reg_rdata = status_word;
        end else if (reg_idx == IDX_CONTROL) begin
            reg_rdata = ctrl_word;
        end
    end

endmodule

// File: rtl/bkpt_match_checker.sv
module bkpt_match_checker
    import bkpt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [IDX_W-1:0]  reg_idx,
    input logic              reg_wr_en,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              step_evt,
    input logic              tswitch_evt,
    input logic              trap_pulse,
    input logic [NUM_BP-1:0] hit_vec,
    input logic [REG_W-1:0]  ctrl_word,
    input logic [REG_W-1:0]  status_word
);

    a_r2_illegal_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_idx == 3'd4 || reg_idx == 3'd5) |-> (reg_rdata == '0));

    a_r3_status_reserved_ones: assert property (@(posedge clk) disable iff (rst)
        (reg_idx == IDX_STATUS) |-> ((reg_rdata & STS_ONES) == STS_ONES));

    a_r4_ctrl_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_idx == IDX_CONTROL) |-> ((reg_rdata & CTL_ZERO) == '0));

    a_r8_trap_bits_sticky: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr_en && reg_idx == IDX_STATUS) |=>
        ((status_word[NUM_BP-1:0] & $past(status_word[NUM_BP-1:0]))
            == $past(status_word[NUM_BP-1:0])));

    a_r8_hit_sets_bit: assert property (@(posedge clk) disable iff (rst)
        (|hit_vec) |=> ((status_word[NUM_BP-1:0] & $past(hit_vec)) == $past(hit_vec)));

    a_r9_step_flag: assert property (@(posedge clk) disable iff (rst)
        step_evt |=> (status_word[STS_STEP_BIT] && trap_pulse));

    a_r9_tswitch_flag: assert property (@(posedge clk) disable iff (rst)
        tswitch_evt |=> status_word[STS_TSW_BIT]);

    a_r10_locals_cleared: assert property (@(posedge clk) disable iff (rst)
        tswitch_evt |=> ((ctrl_word & CTL_LOCALS) == '0));

    a_r11_trap_has_cause: assert property (@(posedge clk) disable iff (rst)
        trap_pulse |-> $past((|hit_vec) || step_evt || tswitch_evt));

    a_r11_cause_gives_trap: assert property (@(posedge clk) disable iff (rst)
        ((|hit_vec) || step_evt || tswitch_evt) |=> trap_pulse);

endmodule

bind bkpt_match_unit bkpt_match_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_idx     (reg_idx),
    .reg_wr_en   (reg_wr_en),
    .reg_rdata   (reg_rdata),
    .step_evt    (step_evt),
    .tswitch_evt (tswitch_evt),
    .trap_pulse  (trap_pulse),
    .hit_vec     (hit_vec),
    .ctrl_word   (ctrl_word),
    .status_word (status_word)
);

// File: tb/tb_bkpt_match_unit.sv
module tb_bkpt_match_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  reg_idx = '0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        evt_valid = 1'b0;
    logic        evt_is_fetch = 1'b0;
    logic        evt_is_write = 1'b0;
    logic [31:0] evt_addr = '0;
    logic [1:0]  evt_size = '0;
    logic        step_evt = 1'b0;
    logic        tswitch_evt = 1'b0;
    logic        trap_pulse;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bkpt_match_unit dut (
        .clk(clk), .rst(rst), .reg_idx(reg_idx), .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_valid(evt_valid),
        .evt_is_fetch(evt_is_fetch), .evt_is_write(evt_is_write),
        .evt_addr(evt_addr), .evt_size(evt_size), .step_evt(step_evt),
        .tswitch_evt(tswitch_evt), .trap_pulse(trap_pulse)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%08h exp=%08h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        reg_idx = idx; reg_wdata = d; reg_wr_en = 1'b1;
        tick();
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] d);
        reg_idx = idx;
        #1;
        d = reg_rdata;
    endtask

    // kind: 0 fetch, 1 read, 2 write
    task automatic set_evt(input int kind, input logic [31:0] a, input logic [1:0] sz);
        evt_valid = 1'b1;
        evt_is_fetch = (kind == 0);
        evt_is_write = (kind == 2);
        evt_addr = a;
        evt_size = sz;
    endtask

    task automatic clr_evt();
        evt_valid = 1'b0; evt_is_fetch = 1'b0; evt_is_write = 1'b0;
        step_evt = 1'b0; tswitch_evt = 1'b0;
    endtask

    function automatic int lsbs_of(input int code);
        case (code)
            0: return 0;
            1: return 1;
            3: return 2;
            default: return 3;
        endcase
    endfunction

    function automatic bit expect_hit(input longint bpa, input int typ, input int lcode,
                                      input int kind, input longint a, input int sz);
        longint blen, bstart, bend, aend;
        blen   = longint'(1) << lsbs_of(lcode);
        bstart = (bpa / blen) * blen;
        bend   = bstart + blen - 1;
        aend   = a + (longint'(1) << sz) - 1;
        case (typ)
            0: return (kind == 0) && (a == bpa);
            1: return (kind == 2) && (a <= bend) && (bstart <= aend);
            3: return (kind != 0) && (a <= bend) && (bstart <= aend);
            default: return 1'b0;
        endcase
    endfunction

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired got=%0d exp=%0d", WATCHDOG, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        logic [31:0] bpa;
        bit          h;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < 4; i++) begin
            rd(3'(i), v); chk("R1 addr reset", v, 32'h0);
        end
        rd(3'd6, v); chk("R1 status reset", v, 32'hFFFF0FF0);
        rd(3'd7, v); chk("R1 control reset", v, 32'h0);
        chk("R1 trap reset", {31'b0, trap_pulse}, 32'h0);

        // R2 register map and illegal indices
        for (int i = 0; i < 4; i++) wr(3'(i), 32'h1111_0000 * (i + 1) + 32'(i));
        wr(3'd4, 32'hDEAD_BEEF);
        wr(3'd5, 32'hCAFE_F00D);
        for (int i = 0; i < 4; i++) begin
            rd(3'(i), v); chk("R2 addr readback", v, 32'h1111_0000 * (i + 1) + 32'(i));
        end
        rd(3'd4, v); chk("R2 idx4 reads zero", v, 32'h0);
        rd(3'd5, v); chk("R2 idx5 reads zero", v, 32'h0);
        rd(3'd6, v); chk("R2 status untouched", v, 32'hFFFF0FF0);
        rd(3'd7, v); chk("R2 control untouched", v, 32'h0);

        // R3 status masks
        wr(3'd6, 32'hFFFF_FFFF); rd(3'd6, v); chk("R3 status all ones", v, 32'hFFFFFFFF);
        wr(3'd6, 32'h0000_A005); rd(3'd6, v); chk("R3 status partial", v, 32'hFFFFAFF5);
        wr(3'd6, 32'h0);         rd(3'd6, v); chk("R3 status cleared", v, 32'hFFFF0FF0);

        // R4 control masks
        wr(3'd7, 32'hFFFF_FFFF); rd(3'd7, v); chk("R4 control ones", v, 32'hFFFF03FF);
        wr(3'd7, 32'h0000_0300); rd(3'd7, v); chk("R4 slowdown stored", v, 32'h00000300);
        wr(3'd7, 32'h0);

        // R6 R7 sweep on breakpoint 0; others disabled
        for (int bo = 0; bo < 2; bo++) begin
            bpa = (bo == 0) ? 32'h1000 : 32'h1005;
            wr(3'd0, bpa);
            for (int lc = 0; lc < 4; lc++) begin
                for (int ty = 0; ty < 4; ty++) begin
                    wr(3'd7, (32'(lc) << 18) | (32'(ty) << 16) | 32'h2);
                    for (int kd = 0; kd < 3; kd++) begin
                        for (int sz = 0; sz < 4; sz++) begin
                            for (int off = -8; off <= 8; off++) begin
                                h = expect_hit(longint'(bpa), ty, lc, kd,
                                               longint'(32'h1000) + off, sz);
                                set_evt(kd, 32'(32'h1000 + off), 2'(sz));
                                reg_idx = 3'd6; reg_wdata = 32'h0; reg_wr_en = 1'b1;
                                tick();
                                reg_wr_en = 1'b0;
                                clr_evt();
                                chk("R6 R7 R11 trap on match", {31'b0, trap_pulse}, {31'b0, h});
                                rd(3'd6, v);
                                chk("R6 R7 R8 status bit", v, 32'hFFFF0FF0 | {31'b0, h});
                            end
                        end
                    end
                end
            end
        end

        // R5 enable combinations, all four breakpoints at one address
        for (int i = 0; i < 4; i++) wr(3'(i), 32'h2000);
        for (int en = 0; en < 256; en++) begin
            logic [3:0] ex;
            for (int i = 0; i < 4; i++) ex[i] = ((en >> (2 * i)) & 3) != 0;
            wr(3'd7, 32'h3333_0000 | 32'(en));
            set_evt(1, 32'h2000, 2'd0);
            reg_idx = 3'd6; reg_wdata = 32'h0; reg_wr_en = 1'b1;
            tick();
            reg_wr_en = 1'b0;
            clr_evt();
            rd(3'd6, v);
            chk("R5 enable pattern", v, 32'hFFFF0FF0 | {28'b0, ex});
        end

        // R8 sticky accumulation
        wr(3'd0, 32'h3000);
        wr(3'd1, 32'h3100);
        wr(3'd7, 32'h0033_000A);
        wr(3'd6, 32'h0);
        set_evt(1, 32'h3000, 2'd0); tick(); clr_evt();
        rd(3'd6, v); chk("R8 first hit", v, 32'hFFFF0FF1);
        set_evt(1, 32'h5000, 2'd0); tick(); clr_evt();
        chk("R11 no trap on miss", {31'b0, trap_pulse}, 32'h0);
        rd(3'd6, v); chk("R8 sticky after miss", v, 32'hFFFF0FF1);
        set_evt(2, 32'h3100, 2'd0); tick(); clr_evt();
        rd(3'd6, v); chk("R8 accumulate", v, 32'hFFFF0FF3);
        tick();
        chk("R11 pulse one cycle", {31'b0, trap_pulse}, 32'h0);
        wr(3'd6, 32'h0); rd(3'd6, v); chk("R8 write clears", v, 32'hFFFF0FF0);

        // R9 single step
        step_evt = 1'b1; tick(); clr_evt();
        chk("R9 R11 step trap", {31'b0, trap_pulse}, 32'h1);
        rd(3'd6, v); chk("R9 step flag", v, 32'hFFFF4FF0);
        tick();
        chk("R11 step pulse ends", {31'b0, trap_pulse}, 32'h0);

        // R10 task switch clears locals
        wr(3'd6, 32'h0);
        wr(3'd7, 32'h3333_03FF);
        tswitch_evt = 1'b1; tick(); clr_evt();
        chk("R9 R11 task switch trap", {31'b0, trap_pulse}, 32'h1);
        rd(3'd7, v); chk("R10 locals cleared", v, 32'h333303AA);
        rd(3'd6, v); chk("R9 tswitch flag", v, 32'hFFFF8FF0);

        // R10 local-only breakpoint stops matching after task switch
        wr(3'd0, 32'h4000);
        wr(3'd7, 32'h0003_0001);
        wr(3'd6, 32'h0);
        tswitch_evt = 1'b1; tick(); clr_evt();
        rd(3'd7, v); chk("R10 local only cleared", v, 32'h00030000);
        wr(3'd6, 32'h0);
        set_evt(1, 32'h4000, 2'd0); tick(); clr_evt();
        chk("R10 no trap after clear", {31'b0, trap_pulse}, 32'h0);
        rd(3'd6, v); chk("R10 no status after clear", v, 32'hFFFF0FF0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule